// File: doc/BRIEF.md
# Auxiliary Control Register Bank

This block is a small bank of byte-wide control registers for a workstation I/O controller. It sits on a simple synchronous register bus with an address, a write strobe, write data and combinational read data. It holds a configuration byte, two auxiliary bytes, a diagnostic byte and a modem-control byte. It also decodes a power-management strobe address and holds one 32-bit system-control word.

A rising edge on the power-fail input sets a sticky status bit in the second auxiliary register, but only when the configuration enable bit is set. The interrupt output is the AND of that status bit and the same enable bit. Software clears the status through a dedicated clear bit in the write data. Other writes produce single-cycle strobes: a CPU halt pulse, a shutdown request and a system reset request.

The diagnostic byte and the system-control word keep their contents through reset. The other registers are cleared by reset.

Top module: `auxc_top`

## Requirements
- R1: The register is chosen by `addr & 0xfff0000`. Configuration is at 0x1800000, auxiliary-1 at 0x1900000, auxiliary-2 at 0x1910000, diagnostic at 0x1a00000, modem control at 0x1b00000 and the power-management strobe at 0x1c00000. Each byte register stores only `wdata[7:0]`, and a read returns that byte in `rdata[7:0]` with the upper bits zero. Reads of the strobe address and of any unmapped address return zero, and reads change no state.
- R2: `irq` is high exactly when auxiliary-2 bit 2 and configuration bit 3 are both 1.
- R3: Each rising edge of `pwr_fail`, sampled on the clock, sets auxiliary-2 bit 2 if configuration bit 3 is 1 at that edge. Otherwise the edge has no effect. Holding `pwr_fail` high produces no further events.
- R4: A write to auxiliary-2 stores `wdata[7:3]`. Bit 2 becomes the OR of its old value and `wdata[2]`, and is then cleared if `wdata[1]` is 1. Bits 1 and 0 always read 0. A power-fail event at the same edge as a clearing write leaves bit 2 set.
- R5: A write to auxiliary-2 with `wdata[0]=1` raises `shutdown_req` for exactly the cycle after the write edge.
- R6: Any write to the power-management address raises `cpu_halt` for the cycle after the write edge and stores nothing.
- R7: Reset clears configuration, auxiliary-1, auxiliary-2 and modem control. It leaves the diagnostic byte and the system-control word unchanged.
- R8: The system-control word is at 0x1f00000 and occupies index 0 of `addr[1:0]`. Indices 1 to 3 read zero and ignore writes, and address bits 15:2 are ignored.
- R9: A write of the system-control word with `wdata[0]=1` raises `sys_reset_req` for the cycle after the write edge. The whole word, including bit 0, is stored and read back until it is next written.
- R10: The three pulse outputs are low during reset and low again one cycle after their pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 28 | Register address |
| wr_en | input | 1 | Write strobe, one write per cycle in which it is high |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| pwr_fail | input | 1 | Power-fail indication, synchronous to `clk` |
| irq | output | 1 | Power-fail interrupt |
| cpu_halt | output | 1 | One-cycle CPU halt strobe |
| shutdown_req | output | 1 | One-cycle shutdown request |
| sys_reset_req | output | 1 | One-cycle system reset request |

## Verification
The checker assumes that `wr_en` stays low while reset is asserted and that `pwr_fail` is synchronous to `clk`. On those terms, every pulse can be traced to a write one edge earlier, and every change of `irq` can be traced to a write or to a sampled rising edge of `pwr_fail`. The stimulus drives every input on the falling edge and holds `wr_en` low through each reset. It leaves at least one idle cycle between bus operations, so the single-cycle width of each pulse is visible. Power-fail edges are driven both alone and in the same cycle as an auxiliary-2 write.

// File: rtl/auxc_pkg.sv
package auxc_pkg;

   // Which register the current address selects
   typedef enum logic [2:0] {
      SEL_NONE = 3'd0,
      SEL_CFG  = 3'd1,
      SEL_AUX1 = 3'd2,
      SEL_AUX2 = 3'd3,
      SEL_DIAG = 3'd4,
      SEL_MDM  = 3'd5,
      SEL_PM   = 3'd6,
      SEL_SYS  = 3'd7
   } auxc_sel_e;

   localparam int unsigned AUXC_ADDR_W = 28;
   localparam logic [AUXC_ADDR_W-1:0] AUXC_MASK      = 28'hfff0000;
   localparam logic [AUXC_ADDR_W-1:0] AUXC_CFG_BASE  = 28'h1800000;
   localparam logic [AUXC_ADDR_W-1:0] AUXC_AUX1_BASE = 28'h1900000;
   localparam logic [AUXC_ADDR_W-1:0] AUXC_AUX2_BASE = 28'h1910000;
   localparam logic [AUXC_ADDR_W-1:0] AUXC_DIAG_BASE = 28'h1a00000;
   localparam logic [AUXC_ADDR_W-1:0] AUXC_MDM_BASE  = 28'h1b00000;
   localparam logic [AUXC_ADDR_W-1:0] AUXC_PM_BASE   = 28'h1c00000;
   localparam logic [AUXC_ADDR_W-1:0] AUXC_SYS_BASE  = 28'h1f00000;

endpackage

// File: rtl/auxc_decode.sv
module auxc_decode #(
   parameter int unsigned ADDR_W    = auxc_pkg::AUXC_ADDR_W,
   parameter int unsigned SYS_IDX_W = 2,
   parameter logic [ADDR_W-1:0] REGION_MASK = auxc_pkg::AUXC_MASK,
   parameter logic [ADDR_W-1:0] CFG_BASE    = auxc_pkg::AUXC_CFG_BASE,
   parameter logic [ADDR_W-1:0] AUX1_BASE   = auxc_pkg::AUXC_AUX1_BASE,
   parameter logic [ADDR_W-1:0] AUX2_BASE   = auxc_pkg::AUXC_AUX2_BASE,
   parameter logic [ADDR_W-1:0] DIAG_BASE   = auxc_pkg::AUXC_DIAG_BASE,
   parameter logic [ADDR_W-1:0] MDM_BASE    = auxc_pkg::AUXC_MDM_BASE,
   parameter logic [ADDR_W-1:0] PM_BASE     = auxc_pkg::AUXC_PM_BASE,
   parameter logic [ADDR_W-1:0] SYS_BASE    = auxc_pkg::AUXC_SYS_BASE
) (
   input  logic [ADDR_W-1:0]   addr,
   output auxc_pkg::auxc_sel_e sel,
   output logic                sys_idx0
);
   import auxc_pkg::*;

   if (SYS_IDX_W < 1 || SYS_IDX_W >= ADDR_W) begin : g_bad_idx
      $error("auxc_decode: SYS_IDX_W out of range");
   end

   logic [ADDR_W-1:0] region;

   always_comb begin
      region = addr & REGION_MASK;
      sel    = SEL_NONE;
      if      (region == CFG_BASE)  sel = SEL_CFG;
      else if (region == AUX1_BASE) sel = SEL_AUX1;
      else if (region == AUX2_BASE) sel = SEL_AUX2;
      else if (region == DIAG_BASE) sel = SEL_DIAG;
      else if (region == MDM_BASE)  sel = SEL_MDM;
      else if (region == PM_BASE)   sel = SEL_PM;
      else if (region == SYS_BASE)  sel = SEL_SYS;
   end

   assign sys_idx0 = (addr[SYS_IDX_W-1:0] == '0);

endmodule

// File: rtl/auxc_plain_reg.sv
module auxc_plain_reg #(
   parameter int unsigned W             = 8,
   parameter bit          KEEP_ON_RESET = 1'b0,
   parameter logic [W-1:0] RST_VAL      = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (W < 1) begin : g_bad_w
      $error("auxc_plain_reg: W must be at least 1");
   end

   if (KEEP_ON_RESET) begin : g_keep
      // Contents survive reset; writes are refused while reset is held
      always_ff @(posedge clk) begin
         if (we && rst_n) q <= d;
      end
   end else begin : g_clear
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)  q <= RST_VAL;
         else if (we) q <= d;
      end
   end

endmodule

// File: rtl/auxc_pf_unit.sv
module auxc_pf_unit #(
   parameter int unsigned REG_W   = 8,
   parameter int unsigned PF_BIT  = 2,
   parameter int unsigned CLR_BIT = 1,
   parameter int unsigned OFF_BIT = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [REG_W-1:0] wdata,
   input  logic             gate_en,
   input  logic             pwr_fail,
   output logic [REG_W-1:0] aux_q,
   output logic             shutdown_req
);

   if (PF_BIT >= REG_W || CLR_BIT >= REG_W || OFF_BIT >= REG_W) begin : g_bad_bit
      $error("auxc_pf_unit: bit index beyond register width");
   end
   if (PF_BIT == CLR_BIT || PF_BIT == OFF_BIT || CLR_BIT == OFF_BIT) begin : g_dup_bit
      $error("auxc_pf_unit: status, clear and off bits must differ");
   end

   logic             pf_prev;
   logic             pf_evt;
   logic [REG_W-1:0] nxt;

   assign pf_evt = pwr_fail & ~pf_prev & gate_en;

   always_comb begin
      nxt = aux_q;
      if (wr) begin
         nxt          = wdata;
         nxt[OFF_BIT] = 1'b0;
         nxt[CLR_BIT] = 1'b0;
         nxt[PF_BIT]  = (aux_q[PF_BIT] | wdata[PF_BIT]) & ~wdata[CLR_BIT];
      end
      // A power-fail event in the same cycle outranks the clear
      nxt[PF_BIT] = nxt[PF_BIT] | pf_evt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         aux_q        <= '0;
         pf_prev      <= 1'b0;
         shutdown_req <= 1'b0;
      end else begin
         aux_q        <= nxt;
         pf_prev      <= pwr_fail;
         shutdown_req <= wr & wdata[OFF_BIT];
      end
   end

endmodule

// File: rtl/auxc_top.sv
module auxc_top #(
   parameter int unsigned ADDR_W      = auxc_pkg::AUXC_ADDR_W,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned REG_W       = 8,
   parameter int unsigned SYS_W       = 32,
   parameter int unsigned SYS_IDX_W   = 2,
   parameter int unsigned PF_BIT      = 2,
   parameter int unsigned CLR_BIT     = 1,
   parameter int unsigned OFF_BIT     = 0,
   parameter int unsigned IRQ_EN_BIT  = 3,
   parameter int unsigned SYS_RST_BIT = 0,
   parameter logic [ADDR_W-1:0] REGION_MASK = auxc_pkg::AUXC_MASK,
   parameter logic [ADDR_W-1:0] CFG_BASE    = auxc_pkg::AUXC_CFG_BASE,
   parameter logic [ADDR_W-1:0] AUX1_BASE   = auxc_pkg::AUXC_AUX1_BASE,
   parameter logic [ADDR_W-1:0] AUX2_BASE   = auxc_pkg::AUXC_AUX2_BASE,
   parameter logic [ADDR_W-1:0] DIAG_BASE   = auxc_pkg::AUXC_DIAG_BASE,
   parameter logic [ADDR_W-1:0] MDM_BASE    = auxc_pkg::AUXC_MDM_BASE,
   parameter logic [ADDR_W-1:0] PM_BASE     = auxc_pkg::AUXC_PM_BASE,
   parameter logic [ADDR_W-1:0] SYS_BASE    = auxc_pkg::AUXC_SYS_BASE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              pwr_fail,
   output logic              irq,
   output logic              cpu_halt,
   output logic              shutdown_req,
   output logic              sys_reset_req
);
   import auxc_pkg::*;

   if (REG_W > DATA_W || SYS_W > DATA_W) begin : g_bad_width
      $error("auxc_top: register wider than the data bus");
   end
   if (IRQ_EN_BIT >= REG_W || SYS_RST_BIT >= SYS_W) begin : g_bad_bit
      $error("auxc_top: control bit beyond register width");
   end

   auxc_sel_e        sel;
   logic             sys_idx0;
   logic [REG_W-1:0] cfg_q, aux1_q, aux2_q, diag_q, mdm_q;
   logic [SYS_W-1:0] sys_q;
   logic             we_cfg, we_aux1, we_aux2, we_diag, we_mdm, we_pm, we_sys;
   logic             halt_q, sysrst_q;

   auxc_decode #(
      .ADDR_W(ADDR_W), .SYS_IDX_W(SYS_IDX_W), .REGION_MASK(REGION_MASK),
      .CFG_BASE(CFG_BASE), .AUX1_BASE(AUX1_BASE), .AUX2_BASE(AUX2_BASE),
      .DIAG_BASE(DIAG_BASE), .MDM_BASE(MDM_BASE), .PM_BASE(PM_BASE),
      .SYS_BASE(SYS_BASE)
   ) dec_i (
      .addr(addr), .sel(sel), .sys_idx0(sys_idx0)
   );

   assign we_cfg  = wr_en && (sel == SEL_CFG);
   assign we_aux1 = wr_en && (sel == SEL_AUX1);
   assign we_aux2 = wr_en && (sel == SEL_AUX2);
   assign we_diag = wr_en && (sel == SEL_DIAG);
   assign we_mdm  = wr_en && (sel == SEL_MDM);
   assign we_pm   = wr_en && (sel == SEL_PM);
   assign we_sys  = wr_en && (sel == SEL_SYS) && sys_idx0;

   auxc_plain_reg #(.W(REG_W), .KEEP_ON_RESET(1'b0)) cfg_i (
      .clk(clk), .rst_n(rst_n), .we(we_cfg), .d(wdata[REG_W-1:0]), .q(cfg_q));
   auxc_plain_reg #(.W(REG_W), .KEEP_ON_RESET(1'b0)) aux1_i (
      .clk(clk), .rst_n(rst_n), .we(we_aux1), .d(wdata[REG_W-1:0]), .q(aux1_q));
   auxc_plain_reg #(.W(REG_W), .KEEP_ON_RESET(1'b1)) diag_i (
      .clk(clk), .rst_n(rst_n), .we(we_diag), .d(wdata[REG_W-1:0]), .q(diag_q));
   auxc_plain_reg #(.W(REG_W), .KEEP_ON_RESET(1'b0)) mdm_i (
      .clk(clk), .rst_n(rst_n), .we(we_mdm), .d(wdata[REG_W-1:0]), .q(mdm_q));
   auxc_plain_reg #(.W(SYS_W), .KEEP_ON_RESET(1'b1)) sys_i (
      .clk(clk), .rst_n(rst_n), .we(we_sys), .d(wdata[SYS_W-1:0]), .q(sys_q));

   auxc_pf_unit #(
      .REG_W(REG_W), .PF_BIT(PF_BIT), .CLR_BIT(CLR_BIT), .OFF_BIT(OFF_BIT)
   ) pf_i (
      .clk(clk), .rst_n(rst_n), .wr(we_aux2), .wdata(wdata[REG_W-1:0]),
      .gate_en(cfg_q[IRQ_EN_BIT]), .pwr_fail(pwr_fail),
      .aux_q(aux2_q), .shutdown_req(shutdown_req)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halt_q   <= 1'b0;
         sysrst_q <= 1'b0;
      end else begin
         halt_q   <= we_pm;
         sysrst_q <= we_sys & wdata[SYS_RST_BIT];
      end
   end

   assign cpu_halt      = halt_q;
   assign sys_reset_req = sysrst_q;
   assign irq           = aux2_q[PF_BIT] & cfg_q[IRQ_EN_BIT];

   always_comb begin
      rdata = '0;
      case (sel)
         SEL_CFG:  rdata[REG_W-1:0] = cfg_q;
         SEL_AUX1: rdata[REG_W-1:0] = aux1_q;
         SEL_AUX2: rdata[REG_W-1:0] = aux2_q;
         SEL_DIAG: rdata[REG_W-1:0] = diag_q;
         SEL_MDM:  rdata[REG_W-1:0] = mdm_q;
         SEL_SYS:  if (sys_idx0) rdata[SYS_W-1:0] = sys_q;
         default:  rdata = '0;
      endcase
   end

endmodule

// File: rtl/auxc_top_chk.sv
module auxc_top_chk #(
   parameter int unsigned ADDR_W    = auxc_pkg::AUXC_ADDR_W,
   parameter int unsigned SYS_IDX_W = 2,
   parameter logic [ADDR_W-1:0] REGION_MASK = auxc_pkg::AUXC_MASK,
   parameter logic [ADDR_W-1:0] AUX2_BASE   = auxc_pkg::AUXC_AUX2_BASE,
   parameter logic [ADDR_W-1:0] PM_BASE     = auxc_pkg::AUXC_PM_BASE,
   parameter logic [ADDR_W-1:0] SYS_BASE    = auxc_pkg::AUXC_SYS_BASE
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic              wr_en,
   input logic              off_bit,
   input logic              rst_bit,
   input logic              pwr_fail,
   input logic              irq,
   input logic              cpu_halt,
   input logic              shutdown_req,
   input logic              sys_reset_req
);

   logic pm_hit, aux2_hit, sys0_hit;
   assign pm_hit   = ((addr & REGION_MASK) == PM_BASE);
   assign aux2_hit = ((addr & REGION_MASK) == AUX2_BASE);
   assign sys0_hit = ((addr & REGION_MASK) == SYS_BASE) && (addr[SYS_IDX_W-1:0] == '0);

   // R6
   halt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_halt == $past(wr_en && pm_hit));

   // R5
   shutdown_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      shutdown_req |-> $past(wr_en && aux2_hit && off_bit));

   // R9
   sysrst_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sys_reset_req |-> $past(wr_en && sys0_hit && rst_bit));

   // R3
   irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> ($past(wr_en) || ($past(pwr_fail) && !$past(pwr_fail, 2))));

   // R4
   irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> $past(wr_en));

   // R10
   pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cpu_halt, shutdown_req, sys_reset_req}));

endmodule

bind auxc_top auxc_top_chk #(
   .ADDR_W(ADDR_W), .SYS_IDX_W(SYS_IDX_W), .REGION_MASK(REGION_MASK),
   .AUX2_BASE(AUX2_BASE), .PM_BASE(PM_BASE), .SYS_BASE(SYS_BASE)
) chk_i (
   .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
   .off_bit(wdata[OFF_BIT]), .rst_bit(wdata[SYS_RST_BIT]),
   .pwr_fail(pwr_fail), .irq(irq), .cpu_halt(cpu_halt),
   .shutdown_req(shutdown_req), .sys_reset_req(sys_reset_req)
);

// File: tb/auxc_top_tb_top.sv
module auxc_top_tb_top;

   localparam logic [27:0] A_MASK = 28'hfff0000;
   localparam logic [27:0] A_CFG  = 28'h1800000;
   localparam logic [27:0] A_AUX1 = 28'h1900000;
   localparam logic [27:0] A_AUX2 = 28'h1910000;
   localparam logic [27:0] A_DIAG = 28'h1a00000;
   localparam logic [27:0] A_MDM  = 28'h1b00000;
   localparam logic [27:0] A_PM   = 28'h1c00000;
   localparam logic [27:0] A_SYS  = 28'h1f00000;
   localparam logic [27:0] A_NONE = 28'h1000000;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [27:0] addr;
   logic        wr_en;
   logic [31:0] wdata;
   logic [31:0] rdata;
   logic        pwr_fail;
   logic        irq, cpu_halt, shutdown_req, sys_reset_req;

   always #5 clk = ~clk;

   auxc_top dut_i (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
      .rdata(rdata), .pwr_fail(pwr_fail), .irq(irq), .cpu_halt(cpu_halt),
      .shutdown_req(shutdown_req), .sys_reset_req(sys_reset_req)
   );

   logic [7:0]  m_cfg, m_aux1, m_aux2, m_diag, m_mdm;
   logic [31:0] m_sys;
   int n_chk = 0;
   int n_err = 0;

   task automatic chk(input bit ok, input string req,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_read(input logic [27:0] a);
      logic [27:0] r;
      r = a & A_MASK;
      case (r)
         A_CFG:   return {24'h0, m_cfg};
         A_AUX1:  return {24'h0, m_aux1};
         A_AUX2:  return {24'h0, m_aux2};
         A_DIAG:  return {24'h0, m_diag};
         A_MDM:   return {24'h0, m_mdm};
         A_SYS:   return (a[1:0] == 2'b00) ? m_sys : 32'h0;
         default: return 32'h0;
      endcase
   endfunction

   function automatic logic exp_irq();
      return m_aux2[2] & m_cfg[3];
   endfunction

   task automatic model_write(input logic [27:0] a, input logic [31:0] d);
      logic b2;
      case (a & A_MASK)
         A_CFG:  m_cfg  = d[7:0];
         A_AUX1: m_aux1 = d[7:0];
         A_AUX2: begin
            b2     = (m_aux2[2] | d[2]) & ~d[1];
            m_aux2 = {d[7:3], b2, 2'b00};
         end
         A_DIAG: m_diag = d[7:0];
         A_MDM:  m_mdm  = d[7:0];
         A_SYS:  if (a[1:0] == 2'b00) m_sys = d;
         default: ;
      endcase
   endtask

   task automatic do_wr(input logic [27:0] a, input logic [31:0] d);
      bit e_halt, e_shut, e_rst;
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      e_halt = ((a & A_MASK) == A_PM);
      e_shut = ((a & A_MASK) == A_AUX2) && d[0];
      e_rst  = ((a & A_MASK) == A_SYS) && (a[1:0] == 2'b00) && d[0];
      model_write(a, d);
      chk(cpu_halt == e_halt, "R6 halt pulse", {31'h0, cpu_halt}, {31'h0, e_halt});
      chk(shutdown_req == e_shut, "R5 shutdown pulse", {31'h0, shutdown_req}, {31'h0, e_shut});
      chk(sys_reset_req == e_rst, "R9 reset pulse", {31'h0, sys_reset_req}, {31'h0, e_rst});
      chk(irq == exp_irq(), "R2 irq after write", {31'h0, irq}, {31'h0, exp_irq()});
      @(negedge clk);
      chk({cpu_halt, shutdown_req, sys_reset_req} == 3'b000, "R10 pulse ends",
          {29'h0, cpu_halt, shutdown_req, sys_reset_req}, 32'h0);
   endtask

   task automatic do_rd(input logic [27:0] a);
      @(negedge clk);
      addr = a; wr_en = 1'b0;
      #1;
      if ((a & A_MASK) == A_SYS)
         chk(rdata == exp_read(a), "R8 sys read", rdata, exp_read(a));
      else
         chk(rdata == exp_read(a), "R1 read", rdata, exp_read(a));
   endtask

   task automatic do_pf();
      @(negedge clk);
      pwr_fail = 1'b1;
      @(negedge clk);
      if (m_cfg[3]) m_aux2[2] = 1'b1;
      chk(irq == exp_irq(), "R3 power-fail edge", {31'h0, irq}, {31'h0, exp_irq()});
      @(negedge clk);
      chk(irq == exp_irq(), "R3 level held", {31'h0, irq}, {31'h0, exp_irq()});
      pwr_fail = 1'b0;
   endtask

   task automatic do_rst();
      @(negedge clk);
      rst_n = 1'b0; wr_en = 1'b0;
      #1;
      chk({irq, cpu_halt, shutdown_req, sys_reset_req} == 4'b0, "R10 outputs in reset",
          {28'h0, irq, cpu_halt, shutdown_req, sys_reset_req}, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      m_cfg = '0; m_aux1 = '0; m_aux2 = '0; m_mdm = '0;
   endtask

   function automatic logic [27:0] pick_addr(input int unsigned k, input logic [31:0] r);
      logic [27:0] b;
      case (k % 8)
         0: b = A_CFG;  1: b = A_AUX1; 2: b = A_AUX2; 3: b = A_DIAG;
         4: b = A_MDM;  5: b = A_PM;   6: b = A_SYS;  default: b = A_NONE;
      endcase
      return b | {12'h0, r[15:0]};
   endfunction

   initial begin
      #(10 * 150000);
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'h00c0ffee));
      rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0; pwr_fail = 1'b0;
      m_cfg = '0; m_aux1 = '0; m_aux2 = '0; m_mdm = '0; m_diag = '0; m_sys = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R7 reset state of the cleared registers
      do_rd(A_CFG); do_rd(A_AUX1); do_rd(A_AUX2); do_rd(A_MDM);
      chk(irq == 1'b0, "R7 irq after reset", {31'h0, irq}, 32'h0);

      // R1 only the low byte stored; R8/R9 system word
      do_wr(A_DIAG | 28'h1234, 32'hdead_bea5); do_rd(A_DIAG);
      do_wr(A_SYS, 32'h1234_5670);             do_rd(A_SYS);
      do_wr(A_SYS | 28'h0008, 32'h0000_0001);  do_rd(A_SYS);
      do_wr(A_SYS | 28'h0002, 32'hffff_ffff);  do_rd(A_SYS); do_rd(A_SYS | 28'h1);

      // R6 strobe stores nothing; R1 unmapped reads zero
      do_wr(A_PM, 32'hffff_ffff); do_rd(A_PM); do_rd(A_NONE);

      // R3 ignored while disabled
      do_pf(); do_rd(A_AUX2);
      // R2/R3 enabled
      do_wr(A_CFG, 32'h08); do_pf(); do_rd(A_AUX2);
      // R4 writing zero keeps the status
      do_wr(A_AUX2, 32'h00); do_rd(A_AUX2);
      // R5 shutdown bit, not stored
      do_wr(A_AUX2, 32'hf9); do_rd(A_AUX2);
      // R4 clear bit
      do_wr(A_AUX2, 32'h02); do_rd(A_AUX2);
      chk(irq == 1'b0, "R4 cleared irq", {31'h0, irq}, 32'h0);

      // R4 event in the same cycle as a clearing write wins
      @(negedge clk);
      addr = A_AUX2; wdata = 32'h02; wr_en = 1'b1; pwr_fail = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; pwr_fail = 1'b0;
      m_aux2 = 8'h04;
      chk(irq == 1'b1, "R4 event beats clear", {31'h0, irq}, 32'h1);
      do_rd(A_AUX2);

      // R7 diagnostic and system word survive reset
      do_wr(A_MDM, 32'h5a); do_wr(A_AUX1, 32'h3c);
      do_rst();
      do_rd(A_DIAG); do_rd(A_SYS); do_rd(A_CFG); do_rd(A_AUX1); do_rd(A_AUX2); do_rd(A_MDM);

      // random mix
      for (int i = 0; i < 600; i++) begin
         int unsigned op;
         op = $urandom % 100;
         if (op < 45)      do_wr(pick_addr($urandom, $urandom), $urandom);
         else if (op < 80) do_rd(pick_addr($urandom, $urandom));
         else if (op < 97) do_pf();
         else              do_rst();
         chk(irq == exp_irq(), "R2 irq", {31'h0, irq}, {31'h0, exp_irq()});
      end

      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule